// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Queued Idle Character

This block sends characters on one wire of a shared multi-drop line where receivers wake on a full character time of idle. Software writes characters into a single holding register. The holding register feeds a frame shift register. An empty flag tells software when the holding register can take the next character. Characters that software loads back to back leave the pin with no idle gap between them. A stray idle bit after an all-ones character could wake a receiver by mistake, so no such bit is ever inserted.

To mark a message boundary, software clears the enable bit and sets it again. The rising edge queues exactly one idle character of all ones. This idle character waits behind the character that is shifting and goes ahead of any character that is buffered. The pin stays driven the whole time. It can run push-pull or open-drain, so several transmitters can share one wire with a pull-up. The same drive-mode bit applies to a second pin, the receive pin, when that pin is borrowed as an output. Baud generation is external: the block takes one tick per sixteenth of a bit.

Top module: `qidle_tx`

## Requirements
- R1: After reset, enable is off, open-drain is off, `txd_oe` is 0, `txd_out` is 1, `data_empty` is 1 and `tx_done` is 1.
- R2: A character frame is one start bit (0), then the data bits LSB first, then one stop bit (1). Each bit lasts 16 `baud_tick` pulses. A frame starts in the clock edge after it becomes due. Any tick in that start edge is not counted.
- R3: `data_empty` goes to 1 at the clock edge that moves the buffered character into the shift register. This happens while that character is still being sent. A write to the data register (`wr_sel`=0) clears `data_empty` at the next edge.
- R4: A control write (`wr_sel`=1) whose bit 0 takes enable from 0 to 1 queues one idle character: 160 ticks of logic 1 on the line. When this idle sits between a shifting character and a buffered one, the two start bits are 320 ticks apart.
- R5: Clearing enable while a frame is shifting lets that frame finish unchanged. The pin stays driven until the stop bit ends.
- R6: A queued idle is sent before the buffered character. So the shifting character, the idle and a buffered character can all be pending at once.
- R7: While enable is 0, data-register writes are ignored. While enable is 0 and no frame is shifting, the TXD pin is released: `txd_oe`=0.
- R8: Characters loaded while the previous frame still shifts follow it with no idle: start bits come 160 ticks apart.
- R9: `tx_done` goes to 1 when a frame or idle ends and nothing is ready to start. It goes to 0 at the edge where an item starts.
- R10: With the open-drain bit (control bit 1) set, `txd_out` is always 0 and `txd_oe` is 1 only while the line must be low.
- R11: The receive-pin output follows the same mode. In push-pull it drives `rxd_drv_val` whenever `rxd_drv_en` is 1. In open-drain it drives 0 only when `rxd_drv_val` is 0.
- R12: Toggling enable off and on several times during one frame still yields exactly one idle character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = data register, 1 = control register |
| wr_data | input | 8 | Write data; for control, bit 0 = enable, bit 1 = open-drain |
| baud_tick | input | 1 | One pulse per sixteenth of a bit time |
| rxd_drv_en | input | 1 | Receive pin used as output |
| rxd_drv_val | input | 1 | Level wanted on the receive pin |
| txd_out | output | 1 | TXD pin output value |
| txd_oe | output | 1 | TXD pin output enable |
| rxd_out | output | 1 | Receive pin output value |
| rxd_oe | output | 1 | Receive pin output enable |
| data_empty | output | 1 | Holding register can take a character |
| tx_done | output | 1 | Shifter finished with nothing pending |

## Verification
All outputs come from registers, so every result is due at the first clock edge after the stimulus that causes it. The one exception is the receive pin, which is combinational in its inputs. A frame, idle and empty flag caused by a write at edge k shows from edge k+1 or k+2, depending on whether the shifter was free. The bench keeps a behavioural model that is advanced on each rising edge from the same inputs. The bench compares the pins and flags with that model at each falling edge, away from the edge that changed them. Spacing between characters is counted in baud ticks from one start-bit fall to the next, not in clocks. This makes the 160- and 320-tick checks independent of the tick rate.

// File: rtl/qtx_pkg.sv
// Shared types for the queued-idle serial transmitter.
// Assumes nothing beyond being compiled before the modules that import it.
package qtx_pkg;

    // Kind of item the holding logic offers to the shifter.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_IDLE = 2'd1,
        SRC_DATA = 2'd2
    } src_e;

endpackage

// File: rtl/qtx_regs.sv
// Control bits, one-entry holding register and the queued-idle flag.
// Offers the next item to the shifter, giving a queued idle priority over
// buffered data. Assumes the shifter asserts take only while avail_o is high.
module qtx_regs
    import qtx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              en_o,
    output logic              od_o,
    output logic              avail_o,
    output src_e              src_o,
    output logic [DATA_W-1:0] data_o,
    output logic              empty_o
);

    logic              en_q;
    logic              od_q;
    logic              idle_pend_q;
    logic              full_q;
    logic [DATA_W-1:0] data_q;

    logic wr_ctl;
    logic wr_dat;
    logic en_rise;
    logic take_idle;
    logic take_data;

    // Decode writes; data is accepted only while enabled.
    always_comb begin
        wr_ctl  = wr_en & wr_sel;
        wr_dat  = wr_en & ~wr_sel & en_q;
        en_rise = wr_ctl & wr_data[0] & ~en_q;
    end

    // Pick what to offer: idle before data, nothing while disabled.
    always_comb begin
        avail_o   = en_q & (idle_pend_q | full_q);
        if (idle_pend_q)      src_o = SRC_IDLE;
        else if (full_q)      src_o = SRC_DATA;
        else                  src_o = SRC_NONE;
        take_idle = take & idle_pend_q;
        take_data = take & ~idle_pend_q & full_q;
    end

    // Control register: enable and open-drain select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            od_q <= 1'b0;
        end else if (wr_ctl) begin
            en_q <= wr_data[0];
            od_q <= wr_data[1];
        end
    end

    // Queued idle: set on an enable rising edge, cleared when the shifter takes it.
    always_ff @(posedge clk) begin
        if (!rst_n)         idle_pend_q <= 1'b0;
        else if (en_rise)   idle_pend_q <= 1'b1;
        else if (take_idle) idle_pend_q <= 1'b0;
    end

    // Holding register occupancy; a new write wins over a same-cycle take.
    always_ff @(posedge clk) begin
        if (!rst_n)         full_q <= 1'b0;
        else if (wr_dat)    full_q <= 1'b1;
        else if (take_data) full_q <= 1'b0;
    end

    // Holding register contents.
    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (wr_dat) data_q <= wr_data;
    end

    assign en_o    = en_q;
    assign od_o    = od_q;
    assign data_o  = data_q;
    assign empty_o = ~full_q;

    AST_EMPTY_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take_data && !wr_dat |=> !full_q);                          // R3
    AST_ONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        take_idle |=> !idle_pend_q);                                // R12
    AST_IGNORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_sel && !en_q |=> $stable(data_q));             // R7
    AST_IDLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        take && idle_pend_q && full_q |=> full_q);                  // R6

endmodule

// File: rtl/qtx_shift.sv
// Frame shift register with bit timing from an external oversampling tick.
// Requests a new item when idle or on the tick that ends the stop bit, so
// consecutive items follow with no gap. Assumes one tick per OSR-th of a bit.
module qtx_shift
    import qtx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              avail,
    input  src_e              src,
    input  logic [DATA_W-1:0] data,
    output logic              take,
    output logic              line,
    output logic              busy,
    output logic              done
);

    localparam int FRAME_W = DATA_W + 2;
    localparam int TCW     = (OSR > 1) ? $clog2(OSR) : 1;
    localparam int BCW     = $clog2(FRAME_W);
    localparam logic [TCW-1:0] TICK_LAST = TCW'(OSR - 1);
    localparam logic [BCW-1:0] BIT_LAST  = BCW'(FRAME_W - 1);

    logic               busy_q;
    logic               tc_q;
    logic [FRAME_W-1:0] frame_q;
    logic [TCW-1:0]     tick_q;
    logic [BCW-1:0]     bit_q;

    logic               bit_end;
    logic               finish;
    logic [FRAME_W-1:0] load_frame;

    // Timing decode: end of a bit, end of the frame, and the take request.
    always_comb begin
        bit_end = busy_q & baud_tick & (tick_q == TICK_LAST);
        finish  = bit_end & (bit_q == BIT_LAST);
        take    = (~busy_q | finish) & avail;
    end

    // Frame image for the offered item: all ones for idle, framed data otherwise.
    always_comb begin
        if (src == SRC_IDLE) load_frame = '1;
        else                 load_frame = {1'b1, data, 1'b0};
    end

    // Shifter sequencing: load, count ticks, shift out, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            tc_q    <= 1'b1;
            frame_q <= '1;
            tick_q  <= '0;
            bit_q   <= '0;
        end else if (take) begin
            busy_q  <= 1'b1;
            tc_q    <= 1'b0;
            frame_q <= load_frame;
            tick_q  <= '0;
            bit_q   <= '0;
        end else if (finish) begin
            busy_q  <= 1'b0;
            tc_q    <= 1'b1;
            frame_q <= '1;
            tick_q  <= '0;
            bit_q   <= '0;
        end else if (busy_q && baud_tick) begin
            if (bit_end) begin
                tick_q  <= '0;
                bit_q   <= bit_q + 1'b1;
                frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    assign line = busy_q ? frame_q[0] : 1'b1;
    assign busy = busy_q;
    assign done = tc_q;

    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && (bit_q == BIT_LAST) |-> line);                    // R2
    AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        finish && avail |=> busy_q);                                // R8
    AST_TC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_q |-> !busy_q);                                          // R9

endmodule

// File: rtl/qtx_pin.sv
// Pin driver: push-pull drives the level whenever owned; open-drain drives
// only a low and releases for a high. Purely combinational.
module qtx_pin (
    input  logic od,
    input  logic own,
    input  logic val,
    output logic pin_out,
    output logic pin_oe
);

    // Select drive style from the mode bit.
    always_comb begin
        if (od) begin
            pin_out = 1'b0;
            pin_oe  = own & ~val;
        end else begin
            pin_out = val;
            pin_oe  = own;
        end
    end

endmodule

// File: rtl/qidle_tx.sv
// Top of the queued-idle serial transmitter. Ties register logic, the frame
// shifter and two mode-controlled pin drivers (TXD and the borrowed RXD).
// Assumes baud_tick is one clock wide and comes from an external divider.
module qidle_tx
    import qtx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    input  logic              rxd_drv_en,
    input  logic              rxd_drv_val,
    output logic              txd_out,
    output logic              txd_oe,
    output logic              rxd_out,
    output logic              rxd_oe,
    output logic              data_empty,
    output logic              tx_done
);

    localparam int NPIN = 2;

    logic              en;
    logic              od;
    logic              avail;
    src_e              src;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              line;
    logic              busy;

    logic [NPIN-1:0]   pin_own;
    logic [NPIN-1:0]   pin_val;
    logic [NPIN-1:0]   pin_out;
    logic [NPIN-1:0]   pin_oe;

    qtx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .take    (take),
        .en_o    (en),
        .od_o    (od),
        .avail_o (avail),
        .src_o   (src),
        .data_o  (hold_data),
        .empty_o (data_empty)
    );

    qtx_shift #(.DATA_W(DATA_W), .OSR(OSR)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .avail     (avail),
        .src       (src),
        .data      (hold_data),
        .take      (take),
        .line      (line),
        .busy      (busy),
        .done      (tx_done)
    );

    // Pin sources: TXD is owned while enabled or still shifting.
    always_comb begin
        pin_own[0] = en | busy;
        pin_val[0] = line;
        pin_own[1] = rxd_drv_en;
        pin_val[1] = rxd_drv_val;
    end

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        qtx_pin u_pin (
            .od      (od),
            .own     (pin_own[p]),
            .val     (pin_val[p]),
            .pin_out (pin_out[p]),
            .pin_oe  (pin_oe[p])
        );
    end

    assign txd_out = pin_out[0];
    assign txd_oe  = pin_oe[0];
    assign rxd_out = pin_out[1];
    assign rxd_oe  = pin_oe[1];

    AST_PIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !od |-> txd_oe);                                    // R5
    AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        od && txd_oe |-> !txd_out);                                 // R10
    AST_RXD_OD: assert property (@(posedge clk) disable iff (!rst_n)
        od && rxd_oe |-> !rxd_out);                                 // R11
    AST_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !en && !busy |-> !txd_oe);                                  // R7

endmodule

// File: tb/tb_qidle_tx.sv
// Bench for qidle_tx: behavioural reference model advanced on each rising
// edge, compared at each falling edge, plus directed tick-spacing checks.
module tb_qidle_tx;

    localparam int DW    = 8;
    localparam int OSR   = 16;
    localparam int FR    = DW + 2;
    localparam int CHAR  = FR * OSR;
    localparam int TDIV  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          baud_tick = 1'b0;
    logic          rxd_drv_en = 1'b0;
    logic          rxd_drv_val = 1'b1;
    logic          txd_out, txd_oe, rxd_out, rxd_oe, data_empty, tx_done;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    qidle_tx #(.DATA_W(DW), .OSR(OSR)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .baud_tick(baud_tick), .rxd_drv_en(rxd_drv_en),
        .rxd_drv_val(rxd_drv_val), .txd_out(txd_out), .txd_oe(txd_oe),
        .rxd_out(rxd_out), .rxd_oe(rxd_oe), .data_empty(data_empty),
        .tx_done(tx_done)
    );

    always #2.5 clk = ~clk;

    // Baud tick every TDIV clocks, driven away from the rising edge.
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv      = (tdiv == TDIV - 1) ? 0 : tdiv + 1;
        baud_tick = (tdiv == 0);
    end

    // ---------------- reference model ----------------
    bit          m_en, m_od, m_idle, m_full, m_busy, m_tc;
    logic [DW-1:0] m_buf;
    logic [FR-1:0] m_frame;
    int          m_left;
    int          tick_edges = 0;

    always @(posedge clk) begin
        bit fin, tk, old_en;
        if (baud_tick) tick_edges++;
        if (!rst_n) begin
            m_en = 0; m_od = 0; m_idle = 0; m_full = 0; m_busy = 0; m_tc = 1;
            m_buf = '0; m_frame = '1; m_left = 0;
        end else begin
            old_en = m_en;
            fin = m_busy && baud_tick && (m_left == 1);
            tk  = (!m_busy || fin) && m_en && (m_idle || m_full);
            if (tk) begin
                if (m_idle) begin
                    m_idle = 0; m_frame = '1;
                end else begin
                    m_full = 0; m_frame = {1'b1, m_buf, 1'b0};
                end
                m_busy = 1; m_left = CHAR; m_tc = 0;
            end else if (fin) begin
                m_busy = 0; m_tc = 1;
            end else if (m_busy && baud_tick) begin
                m_left--;
            end
            if (wr_en && wr_sel) begin
                if (wr_data[0] && !old_en) m_idle = 1;
                m_en = wr_data[0];
                m_od = wr_data[1];
            end
            if (wr_en && !wr_sel && old_en) begin
                m_buf = wr_data; m_full = 1;
            end
        end
    end

    function automatic bit exp_line();
        if (!m_busy) return 1'b1;
        return m_frame[(CHAR - m_left) / OSR];
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model, plus start-bit and pin monitors.
    int  falls[$];
    bit  prev_lvl = 1'b1;
    bit  oe_drop = 1'b0;
    bit  od_high = 1'b0;
    bit  cmp_on = 1'b0;
    always @(negedge clk) begin
        bit lvl, eo, eout, el, own;
        cyc++;
        lvl = txd_oe ? txd_out : 1'b1;
        if (prev_lvl && !lvl) falls.push_back(tick_edges);
        prev_lvl = lvl;
        if (!txd_oe) oe_drop = 1'b1;
        if (txd_oe && txd_out) od_high = 1'b1;
        if (cmp_on) begin
            el   = exp_line();
            own  = m_en || m_busy;
            eo   = own && (m_od ? !el : 1'b1);
            eout = m_od ? 1'b0 : el;
            check(txd_oe == eo,   "R2 txd_oe", txd_oe, eo);
            check(txd_out == eout, "R2 txd_out", txd_out, eout);
            check(data_empty == !m_full, "R3 data_empty", data_empty, !m_full);
            check(tx_done == m_tc, "R9 tx_done", tx_done, m_tc);
        end
    end

    // Watchdog: a hang counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic wr(bit sel, logic [DW-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_tc();
        wait_cyc(3);
        while (!tx_done) @(negedge clk);
    endtask

    task automatic wait_empty();
        while (!data_empty) @(negedge clk);
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R1 reset state
        check(txd_oe == 0, "R1 txd_oe", txd_oe, 0);
        check(txd_out == 1, "R1 txd_out", txd_out, 1);
        check(data_empty == 1, "R1 data_empty", data_empty, 1);
        check(tx_done == 1, "R1 tx_done", tx_done, 1);

        // R7: data write while disabled is ignored, pin stays released
        wr(1'b0, 8'h00);
        wait_cyc(2);
        check(data_empty == 1, "R7 ignored write", data_empty, 1);
        check(txd_oe == 0, "R7 released", txd_oe, 0);

        // Enable (push-pull): preamble idle, then character A
        falls.delete();
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h00);
        wait_cyc(2);
        check(tx_done == 0, "R9 busy after start", tx_done, 0);
        check(data_empty == 0, "R6 data waits behind idle", data_empty, 0);
        wait_tc();
        check(falls.size() == 1, "R7 no stray frame from disabled write", falls.size(), 1);

        // R8: back-to-back characters, no gap; R3 empty set while shifting
        falls.delete();
        wr(1'b0, 8'h00);
        wr(1'b0, 8'h00);
        check(data_empty == 0, "R3 cleared by write", data_empty, 0);
        wait_empty();
        check(tx_done == 0, "R3 empty before end", tx_done, 0);
        wr(1'b0, 8'h00);
        wait_empty();
        wait_tc();
        check(falls.size() == 3, "R8 frame count", falls.size(), 3);
        if (falls.size() == 3) begin
            check(falls[1] - falls[0] == CHAR, "R8 spacing 1", falls[1] - falls[0], CHAR);
            check(falls[2] - falls[1] == CHAR, "R8 spacing 2", falls[2] - falls[1], CHAR);
        end

        // R4/R6/R5: queued idle between shifting A and buffered B
        falls.delete();
        wr(1'b0, 8'h00);
        wait_empty();
        oe_drop = 1'b0;
        wr(1'b1, 8'h00);
        check(txd_oe == 1, "R5 pin held after disable", txd_oe, 1);
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h00);
        wait_tc();
        check(oe_drop == 0, "R5 pin never released", oe_drop, 0);
        check(falls.size() == 2, "R6 frame count", falls.size(), 2);
        if (falls.size() == 2)
            check(falls[1] - falls[0] == 2 * CHAR, "R4 one idle", falls[1] - falls[0], 2 * CHAR);

        // R12: several toggles during one frame still give one idle
        falls.delete();
        wr(1'b0, 8'h00);
        wait_empty();
        for (int i = 0; i < 3; i++) begin
            wr(1'b1, 8'h00);
            wait_cyc(20);
            wr(1'b1, 8'h01);
            wait_cyc(40);
        end
        wr(1'b0, 8'h00);
        wait_tc();
        if (falls.size() == 2)
            check(falls[1] - falls[0] == 2 * CHAR, "R12 single idle", falls[1] - falls[0], 2 * CHAR);
        else
            check(0, "R12 frame count", falls.size(), 2);

        // R2: LSB-first pattern, checked each cycle against the model
        wr(1'b0, 8'h35);
        wr(1'b0, 8'hCA);
        wait_tc();

        // R5/R7: disable mid-frame, frame finishes, then pin released
        falls.delete();
        wr(1'b0, 8'h00);
        wait_cyc(30);
        wr(1'b1, 8'h00);
        check(txd_oe == 1, "R5 still driving", txd_oe, 1);
        wait_tc();
        check(falls.size() == 1, "R5 frame completed", falls.size(), 1);
        wait_cyc(1);
        check(txd_oe == 0, "R7 released after frame", txd_oe, 0);

        // R10: open-drain mode
        falls.delete();
        od_high = 1'b0;
        wr(1'b1, 8'h03);
        wr(1'b0, 8'h00);
        wait_tc();
        check(od_high == 0, "R10 never drives high", od_high, 0);
        check(txd_oe == 0, "R10 idle released", txd_oe, 0);
        check(falls.size() == 1, "R10 low seen on line", falls.size(), 1);

        // R11: receive pin as output follows the same mode (open-drain now)
        rxd_drv_en = 1'b1; rxd_drv_val = 1'b0;
        #1;
        check(rxd_oe == 1 && rxd_out == 0, "R11 od low", {rxd_oe, rxd_out}, 2);
        rxd_drv_val = 1'b1;
        #1;
        check(rxd_oe == 0, "R11 od high released", rxd_oe, 0);
        wait_cyc(1);
        wr(1'b1, 8'h01);
        wait_cyc(1);
        check(rxd_oe == 1 && rxd_out == 1, "R11 push-pull high", {rxd_oe, rxd_out}, 3);
        rxd_drv_en = 1'b0;
        #1;
        check(rxd_oe == 0, "R11 not used", rxd_oe, 0);
        wait_tc();
        wait_cyc(5);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule